// File: doc/BRIEF.md
# Embedded Sync Code Video Decoder

This block takes a 10-bit parallel video word stream, one word per pixel clock, in which frame and line timing is carried inside the data rather than on separate sync wires. It looks for a fixed three-word preamble (0x3FF, 0x000, 0x000 on consecutive clocks) and classifies the word that follows as one of four timing codes. From these codes it produces a pixel stream with a valid strobe, plus one-cycle pulses for line start, line end and frame start.

It also checks the geometry of what it receives. It counts the pixels of every active line and the active lines of every frame, and compares them with the expected values. Any word after a full preamble that is not a known code sets a sticky error flag, and the decoder goes back to searching. Filler words that pad the idle parts of each line (alternating 0x200 and 0x040) are never taken as pixels or codes. Typical use is behind a deserializer, feeding a frame buffer writer or a pixel pipeline.

Top module: `emb_sync_decoder`

## Requirements
- R1: A code word is decoded only when it directly follows the words 0x3FF, 0x000, 0x000 on three consecutive clocks. A lone 0x3FF, or 0x3FF followed by 0x000 and a non-zero word, inside an active line is delivered as an ordinary pixel.
- R2: After a preamble, 0x200 means active line start and 0x240 means active line end. `line_start` or `line_end` is high for exactly the one cycle that follows the clock edge that sampled the code word.
- R3: `pix_valid` is high only for words strictly between an active start code and the next active end code. The preamble and code words are excluded. A pixel word sampled at edge k is shown on `pix_data` with `pix_valid` high in the cycle after edge k+3.
- R4: Words outside active lines, including the 0x200/0x040 fillers, never raise `pix_valid` and never produce a marker.
- R5: `frame_start` pulses together with `line_start` on the first active start code after a blanking start (0x2AC) or blanking end (0x2D8) code. An active start code with no blanking code since the previous one, or since reset, gives no `frame_start`.
- R6: If a full preamble is followed by any word that is not one of the four codes, `sync_err` goes high in the next cycle and stays high until reset. Decoding of later preambles continues normally.
- R7: `line_len_err` pulses together with `line_end` when the number of pixels delivered for that line differs from ACT_PIXELS (default 640). This includes lines with no pixels.
- R8: On each blanking start code, `frame_lines` loads the number of active start codes seen since the previous blanking start code (or reset) and holds it until the next one. `frame_err` pulses in that same cycle if the number differs from ACT_LINES (default 480).
- R9: The reset is synchronous and active low. While it is applied, all outputs are zero and `in_word` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_word | input | 10 | Received video word |
| pix_data | output | 10 | Pixel word, meaningful when pix_valid is high |
| pix_valid | output | 1 | Pixel strobe |
| line_start | output | 1 | Active line start code seen (one-cycle pulse) |
| line_end | output | 1 | Active line end code seen (one-cycle pulse) |
| frame_start | output | 1 | First active line start after a blanking code (one-cycle pulse) |
| sync_err | output | 1 | Sticky: a preamble was followed by an unknown word |
| line_len_err | output | 1 | Pulse with line_end when the pixel count is wrong |
| frame_err | output | 1 | Pulse at blanking start when the active line count is wrong |
| frame_lines | output | $clog2(ACT_LINES+2) | Active line count latched at the last blanking start |

## Verification
A wrong preamble match state shows at once: a marker is missing, or a spurious one appears, in the cycle right after the code word. A fault in the pixel delay line appears as up to three extra or missing valid pixels at the end of a line, which the port checks see before or with `line_end`. Faults in the line or frame counters stay hidden until the end of the line or the next blanking start. That makes them the slowest to show, up to one frame later, so the stimulus includes short, long, empty and missing lines.

// File: rtl/evd_pkg.sv
// Shared constants, types and helper functions for the embedded sync decoder.
// Assumes a 10-bit word and a fixed three-word preamble before every code.
package evd_pkg;
    localparam int WORD_W  = 10;
    localparam int PRE_LEN = 3;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t PRE_HEAD  = 10'h3FF;
    localparam word_t PRE_ZERO  = 10'h000;
    localparam word_t C_SAV_ACT = 10'h200;
    localparam word_t C_EAV_ACT = 10'h240;
    localparam word_t C_SAV_BLK = 10'h2AC;
    localparam word_t C_EAV_BLK = 10'h2D8;

    typedef enum logic [2:0] {
        K_NONE,
        K_SAV_ACT,
        K_EAV_ACT,
        K_SAV_BLK,
        K_EAV_BLK,
        K_BAD
    } kind_t;

    // Expected preamble word at position idx.
    function automatic word_t pre_word(int idx);
        return (idx == 0) ? PRE_HEAD : PRE_ZERO;
    endfunction

    // Map the word after a preamble to a code kind.
    function automatic kind_t classify(word_t w);
        case (w)
            C_SAV_ACT: return K_SAV_ACT;
            C_EAV_ACT: return K_EAV_ACT;
            C_SAV_BLK: return K_SAV_BLK;
            C_EAV_BLK: return K_EAV_BLK;
            default:   return K_BAD;
        endcase
    endfunction
endpackage

// File: rtl/evd_code_finder.sv
// Tracks how much of the preamble has been seen and classifies the word that
// follows a complete preamble. The kind output is combinational and valid in
// the cycle the code word is on the input. Assumes back-to-back words, one per clock.
module evd_code_finder
    import evd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t word_in,
    output kind_t kind
);
    localparam int PW = $clog2(PRE_LEN + 1);

    logic [PW-1:0] match_q;
    logic [PW-1:0] match_d;
    logic          armed;

    assign armed = (match_q == PW'(PRE_LEN));

    // Classify the current word only when the full preamble precedes it.
    always_comb begin
        kind = armed ? classify(word_in) : K_NONE;
    end

    // Advance, restart or clear the preamble match position.
    always_comb begin
        if (!armed && (word_in == pre_word(int'(match_q)))) begin
            match_d = match_q + PW'(1);
        end else if (word_in == PRE_HEAD) begin
            match_d = PW'(1);
        end else begin
            match_d = '0;
        end
    end

    // Hold the preamble match position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
        end else begin
            match_q <= match_d;
        end
    end
endmodule

// File: rtl/evd_pixel_align.sv
// Delays tagged words by DEPTH clocks so that the preamble words in front of a
// code can be untagged once the code is recognised. The flush input clears
// every tag already in flight. Assumes DEPTH is one more than the preamble length.
module evd_pixel_align
    import evd_pkg::*;
#(
    parameter int DEPTH = PRE_LEN + 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  word_t word_in,
    input  logic  tag_in,
    input  logic  flush,
    output word_t pix_data,
    output logic  pix_valid
);
    word_t data_q [DEPTH];
    logic  vld_q  [DEPTH];

    // Shift words and tags through the delay line, dropping tags on flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                data_q[i] <= '0;
                vld_q[i]  <= 1'b0;
            end
        end else begin
            data_q[0] <= word_in;
            vld_q[0]  <= tag_in;
            for (int i = 1; i < DEPTH; i++) begin
                data_q[i] <= data_q[i-1];
                vld_q[i]  <= vld_q[i-1] && !flush;
            end
        end
    end

    assign pix_data  = data_q[DEPTH-1];
    assign pix_valid = vld_q[DEPTH-1];
endmodule

// File: rtl/evd_geometry_check.sv
// Counts delivered pixels per active line and active line starts per frame.
// It flags a wrong line length at the end code and a wrong line count at the
// blanking start code. Both counters saturate, so an overrun cannot wrap to a good value.
module evd_geometry_check
    import evd_pkg::*;
#(
    parameter int ACT_PIXELS = 640,
    parameter int ACT_LINES  = 480,
    localparam int LCW = $clog2(ACT_LINES + 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  kind_t          kind,
    input  logic           pix_valid,
    output logic           line_len_err,
    output logic           frame_err,
    output logic [LCW-1:0] frame_lines
);
    localparam int PCW = $clog2(ACT_PIXELS + 2);

    logic [PCW-1:0] pix_cnt;
    logic [PCW:0]   pix_total;
    logic [LCW-1:0] line_cnt;

    assign pix_total = {1'b0, pix_cnt} + (PCW+1)'(pix_valid);

    // Count delivered pixels since the last active start code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_cnt <= '0;
        end else if (kind == K_SAV_ACT) begin
            pix_cnt <= '0;
        end else if (pix_valid && (pix_cnt != '1)) begin
            pix_cnt <= pix_cnt + PCW'(1);
        end
    end

    // Flag a wrong pixel count when the active end code arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_len_err <= 1'b0;
        end else begin
            line_len_err <= (kind == K_EAV_ACT) && (pix_total != (PCW+1)'(ACT_PIXELS));
        end
    end

    // Count active start codes since the last blanking start code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= '0;
        end else if (kind == K_SAV_BLK) begin
            line_cnt <= '0;
        end else if ((kind == K_SAV_ACT) && (line_cnt != '1)) begin
            line_cnt <= line_cnt + LCW'(1);
        end
    end

    // Latch the frame's line count and flag a mismatch at blanking start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_lines <= '0;
            frame_err   <= 1'b0;
        end else begin
            frame_err <= (kind == K_SAV_BLK) && (line_cnt != LCW'(ACT_LINES));
            if (kind == K_SAV_BLK) begin
                frame_lines <= line_cnt;
            end
        end
    end
endmodule

// File: rtl/emb_sync_decoder.sv
// Top of the embedded sync decoder. It finds the preamble and code words in
// the incoming stream, delivers active pixels with a strobe, pulses line and
// frame markers, and checks the line and frame geometry. Assumes one word per
// clock and a synchronous active-low reset.
module emb_sync_decoder
    import evd_pkg::*;
#(
    parameter int ACT_PIXELS = 640,
    parameter int ACT_LINES  = 480,
    localparam int LINE_CW = $clog2(ACT_LINES + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  in_word,
    output logic [WORD_W-1:0]  pix_data,
    output logic               pix_valid,
    output logic               line_start,
    output logic               line_end,
    output logic               frame_start,
    output logic               sync_err,
    output logic               line_len_err,
    output logic               frame_err,
    output logic [LINE_CW-1:0] frame_lines
);
    kind_t kind;
    logic  in_line_q;
    logic  blank_seen_q;
    logic  code_ok;
    logic  tag;

    evd_code_finder u_finder (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_in (in_word),
        .kind    (kind)
    );

    assign code_ok = (kind != K_NONE) && (kind != K_BAD);
    assign tag     = in_line_q && !code_ok;

    evd_pixel_align #(.DEPTH(PRE_LEN + 1)) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_in   (in_word),
        .tag_in    (tag),
        .flush     (code_ok),
        .pix_data  (pix_data),
        .pix_valid (pix_valid)
    );

    evd_geometry_check #(
        .ACT_PIXELS (ACT_PIXELS),
        .ACT_LINES  (ACT_LINES)
    ) u_geom (
        .clk          (clk),
        .rst_n        (rst_n),
        .kind         (kind),
        .pix_valid    (pix_valid),
        .line_len_err (line_len_err),
        .frame_err    (frame_err),
        .frame_lines  (frame_lines)
    );

    // Track whether the stream is inside an active line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_line_q <= 1'b0;
        end else if (kind == K_SAV_ACT) begin
            in_line_q <= 1'b1;
        end else if (code_ok) begin
            in_line_q <= 1'b0;
        end
    end

    // Remember a blanking code since the last active start code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank_seen_q <= 1'b0;
        end else if ((kind == K_SAV_BLK) || (kind == K_EAV_BLK)) begin
            blank_seen_q <= 1'b1;
        end else if (kind == K_SAV_ACT) begin
            blank_seen_q <= 1'b0;
        end
    end

    // Register one-cycle line and frame markers from the decoded code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_start  <= 1'b0;
            line_end    <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            line_start  <= (kind == K_SAV_ACT);
            line_end    <= (kind == K_EAV_ACT);
            frame_start <= (kind == K_SAV_ACT) && blank_seen_q;
        end
    end

    // Set the sticky error on an unknown word after a full preamble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_err <= 1'b0;
        end else if (kind == K_BAD) begin
            sync_err <= 1'b1;
        end
    end
endmodule

// File: rtl/evd_checker.sv
// Port-level properties of the embedded sync decoder, bound to its top.
module evd_checker
    import evd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] in_word,
    input logic              pix_valid,
    input logic              line_start,
    input logic              line_end,
    input logic              frame_start,
    input logic              sync_err,
    input logic              line_len_err,
    input logic              frame_err
);
    // R1: a marker needs the full preamble in front of its code word.
    a_r1_preamble_before_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start || line_end) |->
            ($past(in_word, 2) == PRE_ZERO && $past(in_word, 3) == PRE_ZERO && $past(in_word, 4) == PRE_HEAD));

    // R2: line start follows the active start code, line end the active end code.
    a_r2_start_code: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> ($past(in_word, 1) == C_SAV_ACT));
    a_r2_end_code: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |-> ($past(in_word, 1) == C_EAV_ACT));

    // R3: no pixel is delivered in the line end cycle.
    a_r3_no_pixel_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |-> !pix_valid);

    // R5: frame start only with a line start.
    a_r5_frame_with_line: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> line_start);

    // R6: the sync error stays set.
    a_r6_sync_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> sync_err);

    // R7: a length error only comes with a line end.
    a_r7_len_err_with_end: assert property (@(posedge clk) disable iff (!rst_n)
        line_len_err |-> line_end);

    // R8: a frame error comes from a blanking start code, never with a line marker.
    a_r8_frame_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> (!line_start && !line_end && $past(in_word, 1) == C_SAV_BLK));
endmodule

bind emb_sync_decoder evd_checker u_evd_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_word      (in_word),
    .pix_valid    (pix_valid),
    .line_start   (line_start),
    .line_end     (line_end),
    .frame_start  (frame_start),
    .sync_err     (sync_err),
    .line_len_err (line_len_err),
    .frame_err    (frame_err)
);

// File: tb/tb_emb_sync_decoder.sv
`timescale 1ns/1ps
// Bench for the embedded sync decoder: builds a stream, records what each
// sampled word should produce, and compares the ports every cycle.
module tb_emb_sync_decoder;
    localparam int P   = 24;
    localparam int L   = 4;
    localparam int LCW = $clog2(L + 2);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [9:0]     in_word = '0;
    logic [9:0]     pix_data;
    logic           pix_valid, line_start, line_end, frame_start;
    logic           sync_err, line_len_err, frame_err;
    logic [LCW-1:0] frame_lines;

    emb_sync_decoder #(.ACT_PIXELS(P), .ACT_LINES(L)) dut (
        .clk(clk), .rst_n(rst_n), .in_word(in_word),
        .pix_data(pix_data), .pix_valid(pix_valid),
        .line_start(line_start), .line_end(line_end), .frame_start(frame_start),
        .sync_err(sync_err), .line_len_err(line_len_err), .frame_err(frame_err),
        .frame_lines(frame_lines)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [9:0] exp_pix [int];
    string      exp_tag [int];
    bit exp_ls [int];
    bit exp_le [int];
    bit exp_fs [int];
    bit exp_lle [int];
    bit exp_fe [int];
    int serr_from = -1;
    int fl_old = 0, fl_new = 0, fl_cyc = 0;
    int checks = 0, errors = 0;
    bit running = 0;
    bit fill_tog = 0;

    bit m_in_line = 0, m_blank = 0;
    int m_pix = 0, m_lines = 0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    // Per-cycle comparison of every output against the recorded expectations.
    always @(negedge clk) begin
        if (running) begin
            if (exp_pix.exists(cyc)) begin
                chk(exp_tag[cyc], "pix_valid", int'(pix_valid), 1);
                chk(exp_tag[cyc], "pix_data", int'(pix_data), int'(exp_pix[cyc]));
            end else begin
                chk("R4", "pix_valid", int'(pix_valid), 0);
            end
            chk("R2", "line_start", int'(line_start), int'(exp_ls.exists(cyc)));
            chk("R2", "line_end", int'(line_end), int'(exp_le.exists(cyc)));
            chk("R5", "frame_start", int'(frame_start), int'(exp_fs.exists(cyc)));
            chk("R7", "line_len_err", int'(line_len_err), int'(exp_lle.exists(cyc)));
            chk("R8", "frame_err", int'(frame_err), int'(exp_fe.exists(cyc)));
            chk("R8", "frame_lines", int'(frame_lines), (cyc >= fl_cyc) ? fl_new : fl_old);
            chk("R6", "sync_err", int'(sync_err), int'(serr_from >= 0 && cyc >= serr_from));
        end
    end

    task automatic put(input logic [9:0] w, output int n);
        @(negedge clk);
        in_word = w;
        n = cyc + 1;
    endtask

    task automatic send_fill();
        int n;
        put(fill_tog ? 10'h040 : 10'h200, n);
        fill_tog = ~fill_tog;
    endtask

    task automatic send_pix(input logic [9:0] w, input string tag);
        int n;
        put(w, n);
        if (m_in_line) begin
            exp_pix[n+3] = w;
            exp_tag[n+3] = tag;
            m_pix++;
        end
    endtask

    task automatic send_code(input logic [9:0] c);
        int n;
        put(10'h3FF, n);
        put(10'h000, n);
        put(10'h000, n);
        put(c, n);
        case (c)
            10'h200: begin
                exp_ls[n] = 1;
                if (m_blank) exp_fs[n] = 1;
                m_blank = 0; m_lines++; m_pix = 0; m_in_line = 1;
            end
            10'h240: begin
                exp_le[n] = 1;
                if (m_pix != P) exp_lle[n] = 1;
                m_in_line = 0;
            end
            10'h2AC: begin
                if (m_lines != L) exp_fe[n] = 1;
                fl_old = fl_new; fl_new = m_lines; fl_cyc = n;
                m_lines = 0; m_blank = 1; m_in_line = 0;
            end
            default: begin
                m_blank = 1; m_in_line = 0;
            end
        endcase
    endtask

    // Preamble followed by an unknown word, used only outside active lines.
    task automatic send_bad(input logic [9:0] w);
        int n;
        put(10'h3FF, n);
        put(10'h000, n);
        put(10'h000, n);
        put(w, n);
        if (serr_from < 0) serr_from = n;
    endtask

    task automatic active_line(input int npix, input bit inject);
        send_code(10'h200);
        for (int i = 0; i < npix; i++) begin
            if (inject && i == 3) send_pix(10'h3FF, "R1");
            else if (inject && i == 4) send_pix(10'h000, "R1");
            else if (inject && i == 5) send_pix(10'h155, "R1");
            else if (inject && i == 9) send_pix(10'h3FF, "R1");
            else send_pix(10'($urandom_range(1, 10'h3FE)), "R3");
        end
        send_code(10'h240);
        for (int i = 0; i < 2 + int'($urandom_range(0, 4)); i++) send_fill();
    endtask

    task automatic blanking(input bit with_bad);
        send_code(10'h2AC);
        for (int i = 0; i < 6; i++) send_fill();
        if (with_bad) begin
            send_bad(10'h123);
            for (int i = 0; i < 3; i++) send_fill();
        end
        send_code(10'h2D8);
        for (int i = 0; i < 4; i++) send_fill();
    endtask

    initial begin
        int n;
        void'($urandom(32'd20240611));
        // R9: junk, including a full code, while reset is held.
        put(10'h3FF, n); put(10'h000, n); put(10'h000, n); put(10'h200, n);
        put(10'h3FF, n); put(10'h000, n); put(10'h000, n); put(10'h155, n);
        @(negedge clk);
        chk("R9", "pix_valid in reset", int'(pix_valid), 0);
        chk("R9", "pix_data in reset", int'(pix_data), 0);
        chk("R9", "line_start in reset", int'(line_start), 0);
        chk("R9", "sync_err in reset", int'(sync_err), 0);
        chk("R9", "frame_lines in reset", int'(frame_lines), 0);
        rst_n = 1'b1;
        running = 1;
        for (int i = 0; i < 5; i++) send_fill();
        // R5 corner: active line with no blanking code seen yet.
        active_line(P, 0);
        blanking(0);                          // R8: one line counted
        // Normal frame with lone preamble-like pixels (R1).
        for (int l = 0; l < L; l++) active_line(P, l == 0);
        blanking(0);
        // R7 and R8: empty, short and long lines, one line missing; R6 in blanking.
        active_line(0, 0);
        active_line(P - 1, 1);
        active_line(P + 2, 0);
        blanking(1);
        // Random frames after the error, decoding resumes (R6).
        for (int f = 0; f < 4; f++) begin
            int nl = ($urandom_range(0, 3) == 0) ? L + 1 : L;
            for (int l = 0; l < nl; l++) begin
                int np = ($urandom_range(0, 4) == 0) ? P - 2 + int'($urandom_range(0, 4)) : P;
                active_line(np, $urandom_range(0, 1) == 1);
            end
            blanking(0);
        end
        for (int i = 0; i < 8; i++) send_fill();
        @(negedge clk);
        running = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule